// File: doc/BRIEF.md
# Seven-Room Adventure Controller

This block is a clocked controller for a small maze game. The player starts in a cave and moves between seven rooms using four direction strobes. Two state machines work together to run the game.

The room machine holds the player's position as a one-hot vector. It flags the sword room to the second machine. The sword machine latches possession of the sword and keeps it until reset. When the player walks into the dragon den, the latched sword flag picks the outcome on the next edge: the victory vault or the graveyard. Both of these rooms trap the player until reset.

All outputs depend only on the registered state. There is no data stream, so every pin is a plain control or status level. Direction strobes need no handshake. A strobe is sampled on each rising clock edge and acted on at that edge.

Top module: `adv_game_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is the cave (`room_onehot` = 7'b0000001) with `sword_held` low.
- R2: `room_onehot` has exactly one bit set. The bit map is: bit 0 cave, bit 1 tunnel, bit 2 river, bit 3 sword stash, bit 4 dragon den, bit 5 victory vault, bit 6 graveyard.
- R3: East in the cave moves to the tunnel on the next edge. South in the tunnel moves to the river.
- R4: West in the river moves to the sword stash. East in the stash moves back to the river. East in the river moves to the dragon den.
- R5: The room does not change in three cases: a direction with no exit from the current room, no strobe at all, or more than one strobe in the same cycle. Strobe bits are north, south, east and west, in that order.
- R6: `sword_found` is high exactly while the player is in the sword stash.
- R7: `sword_held` rises on the edge after a cycle spent in the stash. It then stays high until reset, whatever rooms are visited.
- R8: The dragon den is left on the next edge with no strobe needed. The player goes to the vault if `sword_held` is high, and to the graveyard otherwise.
- R9: `win` is high exactly in the vault and `dead` is high exactly in the graveyard. `win` never appears without `sword_held`.
- R10: The vault and the graveyard ignore all strobes. Only reset leaves them.
- R11: Reset wins over any direction strobe asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| go_north | input | 1 | North strobe |
| go_south | input | 1 | South strobe |
| go_east | input | 1 | East strobe |
| go_west | input | 1 | West strobe |
| room_onehot | output | 7 | Current room, one-hot |
| sword_found | output | 1 | Player is standing in the sword stash |
| sword_held | output | 1 | Sword has been collected |
| win | output | 1 | Player is in the victory vault |
| dead | output | 1 | Player is in the graveyard |

## Verification
The bench builds the block with its default constants: seven rooms and four direction strobes. This small state space lets a seeded random walk reach every exit, both endings and repeated visits to the stash within a few thousand cycles. Directed sequences pin down the winning route and a sword-less death. They also cover simultaneous strobes, and reset asserted together with a strobe and from inside a terminal room.

// File: rtl/adv_pkg.sv
package adv_pkg;
  localparam int ROOM_N = 7;
  localparam int DIR_N  = 4;

  // room bit positions
  localparam int RM_CAVE   = 0;
  localparam int RM_TUNNEL = 1;
  localparam int RM_RIVER  = 2;
  localparam int RM_STASH  = 3;
  localparam int RM_DEN    = 4;
  localparam int RM_VAULT  = 5;
  localparam int RM_GRAVE  = 6;

  // direction bit positions
  localparam int DR_NORTH = 0;
  localparam int DR_SOUTH = 1;
  localparam int DR_EAST  = 2;
  localparam int DR_WEST  = 3;

  typedef logic [ROOM_N-1:0] room_vec_t;
  typedef logic [DIR_N-1:0]  dir_vec_t;

  function automatic room_vec_t room_bit(input int idx);
    return room_vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/adv_dir_decode.sv
module adv_dir_decode
  import adv_pkg::*;
(
  input  dir_vec_t raw,
  output dir_vec_t mv
);
  localparam int CW = $clog2(DIR_N + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DIR_N; i++) begin
      cnt = cnt + CW'(raw[i]);
    end
  end

  // only a single strobe counts as a move
  assign mv = (cnt == CW'(1)) ? raw : '0;
endmodule

// File: rtl/adv_sword_fsm.sv
module adv_sword_fsm (
  input  logic clk,
  input  logic rst,
  input  logic in_stash,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= held | in_stash;
  end

  AST_HELD_STICKY: assert property (@(posedge clk) disable iff (rst)
    held |=> held); // R7
  AST_HELD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(in_stash)); // R7
  AST_HELD_RESET: assert property (@(posedge clk)
    rst |=> !held); // R1
endmodule

// File: rtl/adv_room_fsm.sv
module adv_room_fsm
  import adv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dir_vec_t  mv,
  input  logic      held,
  output room_vec_t room
);
  room_vec_t nxt;

  always_comb begin
    nxt = room;
    if (room[RM_CAVE] && mv[DR_EAST])
      nxt = room_bit(RM_TUNNEL);
    else if (room[RM_TUNNEL] && mv[DR_SOUTH])
      nxt = room_bit(RM_RIVER);
    else if (room[RM_RIVER] && mv[DR_WEST])
      nxt = room_bit(RM_STASH);
    else if (room[RM_RIVER] && mv[DR_EAST])
      nxt = room_bit(RM_DEN);
    else if (room[RM_STASH] && mv[DR_EAST])
      nxt = room_bit(RM_RIVER);
    else if (room[RM_DEN])
      nxt = held ? room_bit(RM_VAULT) : room_bit(RM_GRAVE);
  end

  always_ff @(posedge clk) begin
    if (rst) room <= room_bit(RM_CAVE);
    else     room <= nxt;
  end

  AST_ROOM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(room)); // R2
  AST_RESET_CAVE: assert property (@(posedge clk)
    rst |=> room == room_bit(RM_CAVE)); // R11
  AST_DEN_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    room[RM_DEN] |=> (room[RM_VAULT] || room[RM_GRAVE])); // R8
  AST_DEN_ARMED: assert property (@(posedge clk) disable iff (rst)
    (room[RM_DEN] && held) |=> room[RM_VAULT]); // R8
  AST_END_ABSORB: assert property (@(posedge clk) disable iff (rst)
    (room[RM_VAULT] || room[RM_GRAVE]) |=> $stable(room)); // R10
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
    (mv == '0 && !room[RM_DEN]) |=> $stable(room)); // R5
endmodule

// File: rtl/adv_game_ctrl.sv
module adv_game_ctrl
  import adv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_north,
  input  logic              go_south,
  input  logic              go_east,
  input  logic              go_west,
  output logic [ROOM_N-1:0] room_onehot,
  output logic              sword_found,
  output logic              sword_held,
  output logic              win,
  output logic              dead
);
  dir_vec_t  raw_dir;
  dir_vec_t  mv;
  room_vec_t room;
  logic      held;

  always_comb begin
    raw_dir           = '0;
    raw_dir[DR_NORTH] = go_north;
    raw_dir[DR_SOUTH] = go_south;
    raw_dir[DR_EAST]  = go_east;
    raw_dir[DR_WEST]  = go_west;
  end

  adv_dir_decode i_dec (.raw(raw_dir), .mv(mv));

  adv_room_fsm i_room (
    .clk(clk), .rst(rst), .mv(mv), .held(held), .room(room)
  );

  adv_sword_fsm i_sword (
    .clk(clk), .rst(rst), .in_stash(room[RM_STASH]), .held(held)
  );

  assign room_onehot = room;
  assign sword_found = room[RM_STASH];
  assign sword_held  = held;
  assign win         = room[RM_VAULT];
  assign dead        = room[RM_GRAVE];

  AST_WIN_NEEDS_SWORD: assert property (@(posedge clk) disable iff (rst)
    win |-> sword_held); // R9
  AST_ENDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(win && dead)); // R9
endmodule

// File: tb/test_adv_game_ctrl.sv
module test_adv_game_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dirs = 4'b0000; // bit0 N, bit1 S, bit2 E, bit3 W
  logic [6:0] room_onehot;
  logic       sword_found, sword_held, win, dead;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int e_room = 0;
  bit e_held = 0;

  always #2.5 clk = ~clk;

  adv_game_ctrl i_adv_game_ctrl (
    .clk(clk), .rst(rst),
    .go_north(dirs[0]), .go_south(dirs[1]),
    .go_east(dirs[2]), .go_west(dirs[3]),
    .room_onehot(room_onehot), .sword_found(sword_found),
    .sword_held(sword_held), .win(win), .dead(dead)
  );

  function automatic int model_next(input int cur, input logic [3:0] d, input bit h);
    int n = cur;
    bit single = ($countones(d) == 1);
    if (cur == 4) return h ? 5 : 6;               // R8
    if (!single) return cur;                      // R5
    case (cur)
      0: if (d[2]) n = 1;                         // R3
      1: if (d[1]) n = 2;                         // R3
      2: if (d[3]) n = 3; else if (d[2]) n = 4;   // R4
      3: if (d[2]) n = 2;                         // R4
      default: n = cur;                           // R10
    endcase
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit r, input logic [3:0] d, input string tag);
    bit nh;
    @(negedge clk);
    rst = r;
    dirs = d;
    @(posedge clk);
    if (r) begin
      e_room = 0;
      e_held = 0;
    end else begin
      nh = e_held | (e_room == 3);
      e_room = model_next(e_room, d, e_held);
      e_held = nh;
    end
    #1;
    chk(tag, int'(room_onehot), int'(7'(1) << e_room));
    chk("R6", int'(sword_found), int'(e_room == 3));
    chk("R7", int'(sword_held), int'(e_held));
    chk("R9", int'(win), int'(e_room == 5));
    chk("R9", int'(dead), int'(e_room == 6));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    logic [3:0] d;
    void'($urandom(32'd4242));
    step(1, 4'b0000, "R1");
    step(1, 4'b0000, "R1");
    // R1 reset state
    chk("R1", int'(room_onehot), 1);
    chk("R1", int'(sword_held), 0);
    // winning route R3 R4 R7 R8 R9
    step(0, 4'b0100, "R3");
    step(0, 4'b0010, "R3");
    step(0, 4'b1000, "R4");
    step(0, 4'b0100, "R4");
    step(0, 4'b1000, "R4");   // re-enter stash, R7 stays set
    step(0, 4'b0100, "R4");
    step(0, 4'b0100, "R4");   // into den
    step(0, 4'b0000, "R8");
    chk("R9", int'(win), 1);
    step(0, 4'b1000, "R10");
    step(0, 4'b0010, "R10");
    // reset together with a strobe: R11
    step(1, 4'b0100, "R11");
    chk("R11", int'(room_onehot), 1);
    // R5 undefined exits, idle, double strobe
    step(0, 4'b0001, "R5");
    step(0, 4'b1000, "R5");
    step(0, 4'b0110, "R5");
    step(0, 4'b0000, "R5");
    // sword-less route to death
    step(0, 4'b0100, "R3");
    step(0, 4'b0010, "R3");
    step(0, 4'b0100, "R4");
    step(0, 4'b0001, "R8");
    chk("R8", int'(dead), 1);
    step(0, 4'b0100, "R10");
    step(1, 4'b0000, "R1");
    // random walk
    for (int i = 0; i < 4000; i++) begin
      r = int'($urandom_range(0, 99));
      if ((e_room >= 5 && r < 30) || r < 2) begin
        step(1, 4'($urandom_range(0, 15)), "R11");
      end else if (r < 15) begin
        step(0, 4'b0000, "R5");
      end else if (r < 25) begin
        d = 4'($urandom_range(0, 15));
        step(0, d, "R5");
      end else begin
        d = 4'(1) << $urandom_range(0, 3);
        step(0, d, "R4");
      end
    end
    done = 1;
    summary();
    $finish;
  end
endmodule